// File: doc/BRIEF.md
# Priority Memory Request Arbiter

This block chooses which of eight request sources a memory sequencer serves next. The sources are a mode-register set, refresh, victim write-back, DMA read, DMA translation fill, DMA write, PCI read completion and CPU miss. Each source raises one bit of a request vector. Three condition flags change the rank of three sources. The flags are refresh overdue, both victim entries full, and both DMA write buffers full. A source whose flag is set takes an urgent slot near the top of the order. Without its flag, the source falls to a background slot near the bottom.

When the sequencer reports idle and no grant is outstanding, the arbiter orders the live requests into eleven priority slots. It registers a one-hot grant for the winning source. The grant holds until the sequencer pulses done, and the arbiter then waits for idle before it makes the next choice.

Top module: `mem_req_arbiter`

## Requirements
- R1: While reset is high and on the first cycle after it, `grant` is all zeros and `grant_valid` is low.
- R2: Request bit positions are: 0 mode set, 1 refresh, 2 victim write-back, 3 DMA read, 4 DMA translation fill, 5 DMA write, 6 PCI read completion, 7 CPU miss. When `seq_idle` is high at a clock edge with no grant outstanding, the winner's grant bit is high after that edge, with `grant_valid` high and at most one bit set. No grant is made while `seq_idle` is low.
- R3: With no request bit set, no grant is made and `grant_valid` stays low.
- R4: An outstanding grant stays unchanged, whatever the requests, flags and `seq_idle` do, until `seq_done` is seen.
- R5: A `seq_done` at an edge clears the grant after that edge. A new grant needs a later edge with `seq_idle` high.
- R6: A mode-set request wins over every other request.
- R7: Refresh ranks second when `refresh_late` is high, and ranks below every other request when it is low.
- R8: Victim write-back ranks third when `victim_full` is high. When the flag is low it ranks below CPU miss but above DMA write and refresh in their background slots.
- R9: DMA read ranks above DMA translation fill, which ranks above an urgent DMA write.
- R10: DMA write is urgent (below translation fill, above PCI completion) only when `dmaw_full` is high. When the flag is low it ranks just above background refresh.
- R11: PCI read completion ranks above CPU miss. CPU miss ranks above background victim write-back, DMA write and refresh.
- R12: A request that drops before any idle edge leaves no trace, and the next choice uses only the requests live at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vec | input | 8 | One request bit per source |
| refresh_late | input | 1 | Refresh is overdue |
| victim_full | input | 1 | Both victim entries hold data |
| dmaw_full | input | 1 | Both DMA write buffers hold data |
| seq_idle | input | 1 | Sequencer can take a new request |
| seq_done | input | 1 | Sequencer finished the granted request |
| grant | output | 8 | One-hot registered grant, by source |
| grant_valid | output | 1 | A grant is outstanding |

## Verification
A wrong slot mapping shows up as the wrong grant bit on the cycle after the idle edge. This is the same cycle in which the choice is made, so an ordering fault is seen within one clock of the stimulus. A stuck or lost busy state shows at the ports in two ways: a grant that changes while it should be held, or a grant that stays after done. Either is visible one edge after the event. The bench therefore samples one edge after each idle edge and after each done pulse, so every fault is caught at the cycle where it first appears.

// File: rtl/mra_pkg.sv
package mra_pkg;
  localparam int NUM_SRC  = 8;
  localparam int NUM_SLOT = 11;

  localparam int SRC_MODE = 0;
  localparam int SRC_REF  = 1;
  localparam int SRC_VIC  = 2;
  localparam int SRC_DMAR = 3;
  localparam int SRC_XLAT = 4;
  localparam int SRC_DMAW = 5;
  localparam int SRC_PCI  = 6;
  localparam int SRC_CPU  = 7;

  // source served by each priority slot, slot 0 highest
  function automatic int slot_src(input int slot);
    case (slot)
      0:       return SRC_MODE;
      1:       return SRC_REF;
      2:       return SRC_VIC;
      3:       return SRC_DMAR;
      4:       return SRC_XLAT;
      5:       return SRC_DMAW;
      6:       return SRC_PCI;
      7:       return SRC_CPU;
      8:       return SRC_VIC;
      9:       return SRC_DMAW;
      default: return SRC_REF;
    endcase
  endfunction

  // condition sense for each slot: 0 none, 1 flag high, 2 flag low
  function automatic int slot_cond(input int slot);
    case (slot)
      1, 2, 5:  return 1;
      8, 9, 10: return 2;
      default:  return 0;
    endcase
  endfunction
endpackage

// File: rtl/mra_slot_map.sv
module mra_slot_map
  import mra_pkg::*;
#(
  parameter int N_SRC  = NUM_SRC,
  parameter int N_SLOT = NUM_SLOT
) (
  input  logic [N_SRC-1:0]  req_vec,
  input  logic              refresh_late,
  input  logic              victim_full,
  input  logic              dmaw_full,
  output logic [N_SLOT-1:0] slot_req
);
  logic [N_SRC-1:0] src_flag;

  always_comb begin
    src_flag           = '0;
    src_flag[SRC_REF]  = refresh_late;
    src_flag[SRC_VIC]  = victim_full;
    src_flag[SRC_DMAW] = dmaw_full;
  end

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    localparam int SRC  = slot_src(s);
    localparam int COND = slot_cond(s);
    if (COND == 1) begin : g_urgent
      assign slot_req[s] = req_vec[SRC] & src_flag[SRC];
    end else if (COND == 2) begin : g_background
      assign slot_req[s] = req_vec[SRC] & ~src_flag[SRC];
    end else begin : g_plain
      assign slot_req[s] = req_vec[SRC];
    end
  end
endmodule

// File: rtl/mra_pick.sv
module mra_pick #(
  parameter int N = 11
) (
  input  logic [N-1:0] cand,
  output logic [N-1:0] win
);
  logic [N:0] above;
  assign above[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign win[i]       = cand[i] & ~above[i];
    assign above[i + 1] = above[i] | cand[i];
  end
endmodule

// File: rtl/mra_slot_to_src.sv
module mra_slot_to_src
  import mra_pkg::*;
#(
  parameter int N_SRC  = NUM_SRC,
  parameter int N_SLOT = NUM_SLOT
) (
  input  logic [N_SLOT-1:0] slot_win,
  output logic [N_SRC-1:0]  src_win
);
  for (genvar d = 0; d < N_SRC; d++) begin : g_src
    logic [N_SLOT-1:0] hit;
    for (genvar s = 0; s < N_SLOT; s++) begin : g_hit
      if (slot_src(s) == d) begin : g_on
        assign hit[s] = slot_win[s];
      end else begin : g_off
        assign hit[s] = 1'b0;
      end
    end
    assign src_win[d] = |hit;
  end
endmodule

// File: rtl/mem_req_arbiter.sv
module mem_req_arbiter
  import mra_pkg::*;
#(
  parameter int N_SRC  = NUM_SRC,
  parameter int N_SLOT = NUM_SLOT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req_vec,
  input  logic             refresh_late,
  input  logic             victim_full,
  input  logic             dmaw_full,
  input  logic             seq_idle,
  input  logic             seq_done,
  output logic [N_SRC-1:0] grant,
  output logic             grant_valid
);
  logic [N_SLOT-1:0] slot_req;
  logic [N_SLOT-1:0] slot_win;
  logic [N_SRC-1:0]  src_win;
  logic              take;

  mra_slot_map #(.N_SRC(N_SRC), .N_SLOT(N_SLOT)) u_map (
    .req_vec      (req_vec),
    .refresh_late (refresh_late),
    .victim_full  (victim_full),
    .dmaw_full    (dmaw_full),
    .slot_req     (slot_req)
  );

  mra_pick #(.N(N_SLOT)) u_pick (
    .cand (slot_req),
    .win  (slot_win)
  );

  mra_slot_to_src #(.N_SRC(N_SRC), .N_SLOT(N_SLOT)) u_back (
    .slot_win (slot_win),
    .src_win  (src_win)
  );

  assign take = ~grant_valid & seq_idle & (|slot_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      grant       <= '0;
      grant_valid <= 1'b0;
    end else if (grant_valid) begin
      if (seq_done) begin
        grant       <= '0;
        grant_valid <= 1'b0;
      end
    end else if (take) begin
      grant       <= src_win;
      grant_valid <= 1'b1;
    end
  end

  // R2: at most one source granted
  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R2: a new grant only follows an idle edge
  p_needs_idle_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_valid) |-> $past(seq_idle));

  // R3: valid matches a set grant bit
  p_valid_has_bit_r3: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> ($countones(grant) == 1));

  // R4: held grant does not move before done
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && !seq_done) |=> ($stable(grant) && grant_valid));

  // R5: done releases the grant
  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && seq_done) |=> !grant_valid);

  // R6: mode set wins when present at the choosing edge
  p_mode_first_r6: assert property (@(posedge clk) disable iff (rst)
    (!grant_valid && seq_idle && req_vec[SRC_MODE]) |=> grant[SRC_MODE]);
endmodule

// File: tb/mem_req_arbiter_test.sv
module mem_req_arbiter_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] req_vec;
  logic       refresh_late, victim_full, dmaw_full;
  logic       seq_idle, seq_done;
  logic [7:0] grant;
  logic       grant_valid;

  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  always #2 clk = ~clk;

  mem_req_arbiter uut (
    .clk(clk), .rst(rst), .req_vec(req_vec),
    .refresh_late(refresh_late), .victim_full(victim_full),
    .dmaw_full(dmaw_full), .seq_idle(seq_idle), .seq_done(seq_done),
    .grant(grant), .grant_valid(grant_valid)
  );

  // req, flags {late, vfull, wfull}, expected grant
  localparam int NV = 18;
  localparam logic [18:0] VEC [NV] = '{
    {8'hFF, 3'b000, 8'h01},  // R6
    {8'hFE, 3'b100, 8'h02},  // R7 urgent refresh
    {8'hFE, 3'b000, 8'h08},  // R9 dma read
    {8'hFC, 3'b010, 8'h04},  // R8 urgent victim
    {8'h84, 3'b000, 8'h80},  // R8 cpu over background victim
    {8'h18, 3'b000, 8'h08},  // R9
    {8'h30, 3'b001, 8'h10},  // R9 fill over urgent write
    {8'h60, 3'b001, 8'h20},  // R10 urgent write over pci
    {8'h60, 3'b000, 8'h40},  // R10 background write below pci
    {8'hC0, 3'b000, 8'h40},  // R11
    {8'hA0, 3'b000, 8'h80},  // R11
    {8'h22, 3'b000, 8'h20},  // R10 write above background refresh
    {8'h06, 3'b000, 8'h04},  // R8 background victim above refresh
    {8'h02, 3'b000, 8'h02},  // R7 lone background refresh
    {8'h26, 3'b100, 8'h02},  // R7
    {8'h85, 3'b111, 8'h01},  // R6
    {8'h00, 3'b111, 8'h00},  // R3
    {8'h24, 3'b011, 8'h04}   // R8 urgent victim over urgent write
  };

  function automatic logic [7:0] ref_pick(input logic [7:0] r, input logic [2:0] f);
    if (r[0])               return 8'h01;
    if (r[1] &&  f[2])      return 8'h02;
    if (r[2] &&  f[1])      return 8'h04;
    if (r[3])               return 8'h08;
    if (r[4])               return 8'h10;
    if (r[5] &&  f[0])      return 8'h20;
    if (r[6])               return 8'h40;
    if (r[7])               return 8'h80;
    if (r[2])               return 8'h04;
    if (r[5])               return 8'h20;
    if (r[1])               return 8'h02;
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // apply at negedge with idle high, sample after the edge, then release
  task automatic one_grant(input logic [7:0] r, input logic [2:0] f,
                           input logic [7:0] exp, input string tag);
    @(negedge clk);
    req_vec = r; {refresh_late, victim_full, dmaw_full} = f; seq_idle = 1'b1;
    @(posedge clk); #1;
    check(tag, grant, exp);
    check({tag, " valid"}, {7'd0, grant_valid}, {7'd0, |exp});
    @(negedge clk);
    seq_idle = 1'b0; req_vec = '0;
    if (|exp) begin
      seq_done = 1'b1;
      @(posedge clk); #1;
      check("R5 release", {7'd0, grant_valid}, 8'h00);
      @(negedge clk);
      seq_done = 1'b0;
    end
  endtask

  initial begin
    rst = 1'b1; req_vec = '0; refresh_late = 0; victim_full = 0; dmaw_full = 0;
    seq_idle = 0; seq_done = 0;
    repeat (3) @(posedge clk); #1;
    check("R1 reset grant", grant, 8'h00);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1 after reset", {7'd0, grant_valid}, 8'h00);

    for (int i = 0; i < NV; i++)
      one_grant(VEC[i][18:11], VEC[i][10:8], VEC[i][7:0], $sformatf("R2 vec %0d", i));

    // R2: idle low blocks a grant
    @(negedge clk); req_vec = 8'h80; seq_idle = 1'b0;
    repeat (2) @(posedge clk); #1;
    check("R2 not idle", grant, 8'h00);

    // R4: hold under changing inputs
    @(negedge clk); seq_idle = 1'b1;
    @(posedge clk); #1;
    check("R4 granted cpu", grant, 8'h80);
    @(negedge clk); req_vec = 8'hFF; refresh_late = 1'b1;
    repeat (3) @(posedge clk); #1;
    check("R4 held", grant, 8'h80);
    @(negedge clk); seq_done = 1'b1; seq_idle = 1'b0;
    @(posedge clk); #1;
    check("R5 cleared", grant, 8'h00);
    @(negedge clk); seq_done = 1'b0;
    @(posedge clk); #1;
    check("R5 no regrant without idle", grant, 8'h00);
    @(negedge clk); seq_idle = 1'b1;
    @(posedge clk); #1;
    check("R5 regrant", grant, 8'h01);
    @(negedge clk); seq_idle = 1'b0; seq_done = 1'b1; req_vec = '0; refresh_late = 0;
    @(posedge clk); #1;
    @(negedge clk); seq_done = 1'b0;

    // R12: request that drops before idle is ignored
    req_vec = 8'h01;
    @(negedge clk); req_vec = 8'h40;
    @(negedge clk); seq_idle = 1'b1;
    @(posedge clk); #1;
    check("R12 dropped request", grant, 8'h40);
    @(negedge clk); seq_idle = 1'b0; seq_done = 1'b1; req_vec = '0;
    @(negedge clk); seq_done = 1'b0;

    // random sweep against the ordering of R6-R11
    for (int k = 0; k < 400; k++) begin
      logic [7:0] r;
      logic [2:0] f;
      r = 8'($urandom);
      f = 3'($urandom);
      if (k % 3 == 0) r = r & 8'($urandom);
      one_grant(r, f, ref_pick(r, f), "R6-R11 random");
    end

    done_run = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule